// File: doc/BRIEF.md
# SONET Path Parity Error Monitor

This block sits on the receive side of a byte-serial STS-3c payload stream, behind pointer processing, which supplies the envelope alignment. It folds every valid byte of each payload envelope into an even-parity BIP-8 word. When the path parity byte of the next envelope arrives, it compares that byte with the stored word. The mismatches go into a saturating path error counter. The step is either the number of differing bit positions or a flat one per envelope.

The block also reads the far-end error nibble from the upper half of the path status byte. It adds that nibble to a second saturating counter, again either by its value or by one per envelope. A sticky status bit and an active-low interrupt report parity errors. A one-cycle indication carries the per-envelope error amount to the transmit side, which uses it to build its own far-end report.

Top module: `pbm_path_monitor`

## Requirements
- R1: Parity covers every byte with `din_vld`=1, from a byte flagged `spe_start` up to the byte before the next `spe_start`. Bytes with `din_vld`=0, and valid bytes before the first `spe_start` after reset, do not affect it.
- R2: The parity byte (flagged `b3_pos`) of an envelope is compared with the parity of the previous envelope. In the first envelope after reset the parity byte is ignored: no counter change and no `tx_rei_vld`.
- R3: With `cfg_b3_per_spe`=0, `b3_err_cnt` grows by the number of set bits in (parity byte XOR expected parity), 0 to 8.
- R4: With `cfg_b3_per_spe`=1, `b3_err_cnt` grows by 1 for a compare with any mismatch and by 0 otherwise.
- R5: With `cfg_rei_per_spe`=0, a valid byte flagged `g1_pos` inside an envelope adds the value of `din[7:4]` to `rei_err_cnt`. Nibble values 9 to 15 add 0.
- R6: With `cfg_rei_per_spe`=1, that byte adds 1 when its nibble is in 1..8 and 0 otherwise.
- R7: `b3_err_sts` goes to 1 on the clock after any mismatching compare and stays 1 until a cycle with `sts_clr`=1. A mismatch in the same cycle as the clear wins.
- R8: `irq_n` is 0 exactly while `b3_err_sts`=1 and `irq_en`=1, and is 1 otherwise.
- R9: On the clock after each compare, `tx_rei_vld` pulses for one cycle, and `tx_rei` holds that compare's counter step (at most 8, and at most 1 in per-envelope mode).
- R10: Both 16-bit counters stop at 0xFFFF instead of wrapping.
- R11: After reset, both counters are 0, `b3_err_sts`=0, `irq_n`=1 and `tx_rei_vld`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 8 | Payload byte |
| din_vld | input | 1 | Byte on `din` is valid |
| spe_start | input | 1 | Valid byte is the first of an envelope |
| b3_pos | input | 1 | Valid byte is the path parity byte |
| g1_pos | input | 1 | Valid byte is the path status byte |
| cfg_b3_per_spe | input | 1 | 1: parity counter steps by one per envelope; 0: steps by bit count |
| cfg_rei_per_spe | input | 1 | 1: far-end counter steps by one per envelope; 0: steps by nibble value |
| irq_en | input | 1 | Interrupt enable |
| sts_clr | input | 1 | Clears the sticky status |
| b3_err_cnt | output | 16 | Saturating path parity error count |
| rei_err_cnt | output | 16 | Saturating far-end error count |
| b3_err_sts | output | 1 | Sticky parity error status |
| irq_n | output | 1 | Active-low interrupt |
| tx_rei | output | 4 | Error amount for the transmit side |
| tx_rei_vld | output | 1 | `tx_rei` is valid this cycle |

## Verification
The stimulus mixes several kinds of envelope:
- Envelopes whose parity byte is correct show that valid bytes alone are folded in, even with invalid gap bytes between them.
- Single-bit and random multi-bit corruptions separate the bit-count step from the per-envelope step.
- Leading bytes before the first envelope, and a corrupted parity byte in that envelope, show that the compare is anchored to the previous envelope.
- Nibble values 0, 8 and 9 to 15 separate value mode from flag mode and check that out-of-range values add nothing.
- A long run of fully corrupted, short envelopes drives both counters into saturation.

// File: rtl/pbm_pkg.sv
package pbm_pkg;
  localparam int BYTE_W = 8;
  localparam int STEP_W = 4;

  // number of ones in a byte
  function automatic logic [STEP_W-1:0] bit_count8(input logic [BYTE_W-1:0] v);
    logic [STEP_W-1:0] n;
    n = '0;
    for (int i = 0; i < BYTE_W; i++) n = n + {{(STEP_W-1){1'b0}}, v[i]};
    return n;
  endfunction

  // far-end nibble; values above eight are not legal error counts
  function automatic logic [STEP_W-1:0] rei_weight(input logic [3:0] nib);
    return (nib > 4'd8) ? '0 : nib;
  endfunction

  // step chosen by mode: raw amount or a single event
  function automatic logic [STEP_W-1:0] step_size(input logic [STEP_W-1:0] raw,
                                                  input logic per_spe);
    return per_spe ? {{(STEP_W-1){1'b0}}, (raw != '0)} : raw;
  endfunction
endpackage

// File: rtl/pbm_bip_acc.sv
module pbm_bip_acc #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         byte_vld,
  input  logic         spe_start,
  input  logic [W-1:0] din,
  output logic [W-1:0] prior_bip,
  output logic         prior_ok,
  output logic         in_spe
);
  logic [W-1:0] acc_q, prev_q;
  logic         started_q, have_prev_q;
  logic         start_evt;

  assign start_evt = byte_vld & spe_start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q       <= '0;
      prev_q      <= '0;
      started_q   <= 1'b0;
      have_prev_q <= 1'b0;
    end else if (start_evt) begin
      acc_q       <= din;
      prev_q      <= acc_q;
      have_prev_q <= started_q;
      started_q   <= 1'b1;
    end else if (byte_vld && started_q) begin
      acc_q <= acc_q ^ din;
    end
  end

  // a parity byte on the start byte itself sees the envelope just closed
  assign prior_bip = start_evt ? acc_q : prev_q;
  assign prior_ok  = start_evt ? started_q : have_prev_q;
  assign in_spe    = started_q | start_evt;

  // R2
  first_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && !started_q) |=> !have_prev_q);

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_vld |=> $stable(acc_q));
endmodule

// File: rtl/pbm_sat_cnt.sv
module pbm_sat_cnt #(
  parameter int W      = 16,
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc_en,
  input  logic [STEP_W-1:0] step,
  output logic [W-1:0]      count
);
  localparam int SUM_W = W + 1;

  logic [SUM_W-1:0] sum;
  logic [W-1:0]     next_cnt;

  assign sum      = {1'b0, count} + {{(SUM_W-STEP_W){1'b0}}, step};
  assign next_cnt = sum[W] ? {W{1'b1}} : sum[W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)      count <= '0;
    else if (inc_en) count <= next_cnt;
  end

  // R10
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(count) == {W{1'b1}}) |-> (count == {W{1'b1}}));

  // R10
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count >= $past(count));
endmodule

// File: rtl/pbm_path_monitor.sv
module pbm_path_monitor
  import pbm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] din,
  input  logic              din_vld,
  input  logic              spe_start,
  input  logic              b3_pos,
  input  logic              g1_pos,
  input  logic              cfg_b3_per_spe,
  input  logic              cfg_rei_per_spe,
  input  logic              irq_en,
  input  logic              sts_clr,
  output logic [CNT_W-1:0]  b3_err_cnt,
  output logic [CNT_W-1:0]  rei_err_cnt,
  output logic              b3_err_sts,
  output logic              irq_n,
  output logic [STEP_W-1:0] tx_rei,
  output logic              tx_rei_vld
);
  logic [BYTE_W-1:0] prior_bip, b3_diff;
  logic              prior_ok, in_spe;
  logic              b3_evt, b3_mis, g1_evt;
  logic [STEP_W-1:0] b3_step, rei_step;

  pbm_bip_acc #(.W(BYTE_W)) u_bip (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_vld  (din_vld),
    .spe_start (spe_start),
    .din       (din),
    .prior_bip (prior_bip),
    .prior_ok  (prior_ok),
    .in_spe    (in_spe)
  );

  assign b3_evt   = din_vld & b3_pos & prior_ok;
  assign b3_diff  = din ^ prior_bip;
  assign b3_mis   = b3_evt & (b3_diff != '0);
  assign b3_step  = step_size(bit_count8(b3_diff), cfg_b3_per_spe);

  assign g1_evt   = din_vld & g1_pos & in_spe;
  assign rei_step = step_size(rei_weight(din[7:4]), cfg_rei_per_spe);

  pbm_sat_cnt #(.W(CNT_W), .STEP_W(STEP_W)) u_b3_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc_en (b3_evt),
    .step   (b3_step),
    .count  (b3_err_cnt)
  );

  pbm_sat_cnt #(.W(CNT_W), .STEP_W(STEP_W)) u_rei_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc_en (g1_evt),
    .step   (rei_step),
    .count  (rei_err_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       b3_err_sts <= 1'b0;
    else if (b3_mis)  b3_err_sts <= 1'b1;
    else if (sts_clr) b3_err_sts <= 1'b0;
  end

  assign irq_n = ~(b3_err_sts & irq_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_rei     <= '0;
      tx_rei_vld <= 1'b0;
    end else begin
      tx_rei_vld <= b3_evt;
      if (b3_evt) tx_rei <= b3_step;
    end
  end

  // R7
  sts_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    b3_mis |=> b3_err_sts);

  // R8
  irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(b3_mis) && irq_en) |-> !irq_n);

  // R9
  tx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rei_vld |-> (tx_rei <= 4'd8));

  // R9
  tx_spe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_rei_vld && $past(cfg_b3_per_spe)) |-> (tx_rei <= 4'd1));
endmodule

// File: tb/pbm_path_monitor_tb.sv
module pbm_path_monitor_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  din = '0;
  logic        din_vld = 1'b0, spe_start = 1'b0, b3_pos = 1'b0, g1_pos = 1'b0;
  logic        cfg_b3_per_spe = 1'b0, cfg_rei_per_spe = 1'b0, irq_en = 1'b1, sts_clr = 1'b0;
  logic [15:0] b3_err_cnt, rei_err_cnt;
  logic        b3_err_sts, irq_n, tx_rei_vld;
  logic [3:0]  tx_rei;

  int checks = 0, failures = 0;
  bit m_started = 0, m_have = 0, m_sts = 0;
  logic [7:0] m_acc = '0, m_prev = '0;
  int m_b3 = 0, m_rei = 0;

  always #2 clk = ~clk;

  pbm_path_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .din(din), .din_vld(din_vld), .spe_start(spe_start),
    .b3_pos(b3_pos), .g1_pos(g1_pos), .cfg_b3_per_spe(cfg_b3_per_spe),
    .cfg_rei_per_spe(cfg_rei_per_spe), .irq_en(irq_en), .sts_clr(sts_clr),
    .b3_err_cnt(b3_err_cnt), .rei_err_cnt(rei_err_cnt), .b3_err_sts(b3_err_sts),
    .irq_n(irq_n), .tx_rei(tx_rei), .tx_rei_vld(tx_rei_vld));

  function automatic int ones(input logic [7:0] v);
    int n = 0;
    logic [7:0] t = v;
    while (t != 0) begin t = t & (t - 8'd1); n++; end
    return n;
  endfunction

  function automatic int sat16(input int v);
    return (v > 65535) ? 65535 : v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] d, input bit vld, input bit st,
                           input bit b3, input bit g1, input bit clr);
    bit mis = 0;
    @(negedge clk);
    din = d; din_vld = vld; spe_start = st; b3_pos = b3; g1_pos = g1; sts_clr = clr;
    @(posedge clk); #1;
    if (vld) begin
      if (st) begin
        if (m_started) begin m_prev = m_acc; m_have = 1; end
        m_started = 1; m_acc = d;
      end else if (m_started) m_acc = m_acc ^ d;
      if (b3) begin
        if (m_have) begin
          int st_exp;
          logic [7:0] x = d ^ m_prev;
          st_exp = cfg_b3_per_spe ? int'(x != 0) : ones(x);
          mis = (x != 0);
          chk(tx_rei_vld === 1'b1 && int'(tx_rei) == st_exp, "R9", int'(tx_rei), st_exp);
          m_b3 = sat16(m_b3 + st_exp);
        end else
          chk(tx_rei_vld === 1'b0, "R2 first envelope skipped", int'(tx_rei_vld), 0);
      end
      if (g1 && m_started) begin
        int w = (d[7:4] > 8) ? 0 : int'(d[7:4]);
        m_rei = sat16(m_rei + (cfg_rei_per_spe ? int'(w != 0) : w));
      end
    end
    if (mis) m_sts = 1;
    else if (clr) m_sts = 0;
  endtask

  task automatic idle(input bit clr);
    send_byte(8'($urandom), 1'b0, 1'($urandom), 1'($urandom), 1'($urandom), clr);
  endtask

  task automatic check_state(input string tag);
    chk(int'(b3_err_cnt) == m_b3, {tag, " R3/R4 b3 count"}, int'(b3_err_cnt), m_b3);
    chk(int'(rei_err_cnt) == m_rei, {tag, " R5/R6 rei count"}, int'(rei_err_cnt), m_rei);
    chk(b3_err_sts == m_sts, {tag, " R7 status"}, int'(b3_err_sts), int'(m_sts));
    chk(irq_n == !(m_sts && irq_en), {tag, " R8 irq"}, int'(irq_n), int'(!(m_sts && irq_en)));
  endtask

  task automatic send_spe(input int len, input int b3i, input int g1i, input logic [7:0] mask,
                          input logic [3:0] nib, input bit gaps, input bit clr_on_b3);
    for (int i = 0; i < len; i++) begin
      logic [7:0] d = 8'($urandom);
      if (gaps && ($urandom % 4 == 0)) idle(1'b0);
      if (i == b3i) d = m_prev ^ mask;
      if (i == g1i) d = {nib, d[3:0]};
      send_byte(d, 1'b1, i == 0, i == b3i, i == g1i, clr_on_b3 && i == b3i);
    end
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R11 reset state
    chk(b3_err_cnt == 0 && rei_err_cnt == 0, "R11 counters", int'(b3_err_cnt), 0);
    chk(b3_err_sts == 0 && irq_n == 1, "R11 status/irq", int'(irq_n), 1);
    chk(tx_rei_vld == 0, "R11 tx_rei_vld", int'(tx_rei_vld), 0);

    // R1 leading valid bytes before any envelope start are ignored
    for (int i = 0; i < 5; i++) send_byte(8'($urandom), 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    // R2 first envelope: corrupted parity byte ignored
    send_spe(12, 3, 5, 8'hA5, 4'd0, 1'b1, 1'b0);
    check_state("R2 first");
    // clean envelope with gaps: no errors (R1)
    send_spe(12, 3, 5, 8'h00, 4'd0, 1'b1, 1'b0);
    check_state("R1 clean");
    // single bit error, bit-count mode (R3)
    send_spe(12, 3, 5, 8'h10, 4'd8, 1'b0, 1'b0);
    check_state("R3 one bit");
    // set-and-clear in same cycle: set wins (R7)
    send_spe(12, 3, 5, 8'hFF, 4'd9, 1'b0, 1'b1);
    check_state("R7 set wins");
    idle(1'b1);
    check_state("R7 cleared");
    // R8 irq masked
    irq_en = 1'b0;
    send_spe(12, 3, 5, 8'h03, 4'd2, 1'b0, 1'b0);
    check_state("R8 masked");
    irq_en = 1'b1;
    #1; check_state("R8 enabled");
    // per-envelope modes (R4, R6)
    cfg_b3_per_spe = 1'b1; cfg_rei_per_spe = 1'b1;
    send_spe(10, 0, 4, 8'hF0, 4'd7, 1'b0, 1'b0);
    check_state("R4/R6 per-spe");
    send_spe(10, 2, 4, 8'h00, 4'd12, 1'b1, 1'b0);
    check_state("R6 illegal nibble");

    // random mix
    for (int k = 0; k < 150; k++) begin
      logic [7:0] mask;
      cfg_b3_per_spe  = 1'($urandom);
      cfg_rei_per_spe = 1'($urandom);
      irq_en          = 1'($urandom);
      case ($urandom % 4)
        0: mask = 8'h00;
        1: mask = 8'h01 << ($urandom % 8);
        default: mask = 8'($urandom);
      endcase
      send_spe(6 + int'($urandom % 20), 1 + int'($urandom % 3), 4 + int'($urandom % 2),
               mask, 4'($urandom), 1'b1, ($urandom % 8) == 0);
      check_state("random");
      if ($urandom % 10 == 0) begin idle(1'b1); check_state("R7 random clear"); end
    end

    // R10 saturation
    cfg_b3_per_spe = 1'b0; cfg_rei_per_spe = 1'b0; irq_en = 1'b1;
    for (int k = 0; k < 8300; k++) send_spe(3, 1, 2, 8'hFF, 4'd8, 1'b0, 1'b0);
    chk(b3_err_cnt == 16'hFFFF, "R10 b3 saturated", int'(b3_err_cnt), 65535);
    chk(rei_err_cnt == 16'hFFFF, "R10 rei saturated", int'(rei_err_cnt), 65535);
    send_spe(3, 1, 2, 8'hFF, 4'd8, 1'b0, 1'b0);
    check_state("R10 held");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule